// File: doc/BRIEF.md
# Row Write Latch and Erase Controller

This block sits between a serial programming command receiver and a flash array. It keeps a bank of sixteen 14-bit write latches. Each load request stores one word in the latch picked by the four low bits of the current address. A program request then streams the whole aligned 16-word row that holds the address at that moment. The row goes into the array one word per cycle, lowest offset first. After the last word all latches go back to the erased value 3FFFh, so untouched words of the row are written with all ones and stay as they were. The array write never erases first.

Erase requests become one-cycle region strobes. Which regions are cleared depends on the current address and on the code protection bit. A bulk erase in program space clears program memory and the configuration word, whatever the protection state. This is the only path that lifts protection. A bulk erase inside the user-ID window also clears the user IDs. A row erase in program space clears one row, but only when protection is off. Inside the user-ID window it clears the user IDs only. Above that window both kinds of erase do nothing. No strobe for calibration words exists.

Top module: `rwl_row_programmer`

## Requirements
- R1: After reset `arr_we_o`, `busy_o` and all erase strobes are 0, and every latch holds 3FFFh.
- R2: A load request stores `req_data_i` in the latch whose index is `cur_addr_i[3:0]`.
- R3: A program request accepted at a clock edge drives `arr_we_o` and `busy_o` high for the next 16 cycles. In cycle k (k = 0..15) `arr_addr_o` is `{cur_addr_i[13:4] at request, k[3:0]}` and `arr_data_o` is latch k. Afterwards both go low.
- R4: A second load to a latch index overwrites it. Seventeen loads at consecutive addresses leave the first latch holding the seventeenth word.
- R5: A latch not loaded since the last program sequence supplies 3FFFh. Every latch returns to 3FFFh when a program sequence ends.
- R6: A bulk erase with `cur_addr_i[13]` = 0 pulses `ers_main_o` and `ers_cfg_o` for one cycle, one cycle after the request, with `ers_uid_o` low, whatever `prot_on_i` is.
- R7: A bulk erase with the address in 2000h..2008h pulses `ers_main_o`, `ers_cfg_o` and `ers_uid_o`. Above 2008h it pulses nothing.
- R8: A row erase with `cur_addr_i[13]` = 0 and `prot_on_i` = 0 pulses `ers_row_o` with `ers_row_addr_o` = address with its low four bits cleared. With `prot_on_i` = 1 it pulses nothing.
- R9: A row erase with the address in 2000h..2008h pulses only `ers_uid_o`, whatever `prot_on_i` is. Above 2008h it pulses nothing.
- R10: While `busy_o` is high every request is ignored. Requests that arrive in the same cycle are served by priority program > bulk > row > load, and the lower ones are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_load_i | input | 1 | Load one word into a latch |
| req_prog_i | input | 1 | Write the latched row to the array |
| req_bulk_i | input | 1 | Bulk erase request |
| req_row_i | input | 1 | Row erase request |
| req_data_i | input | 14 | Word to load |
| cur_addr_i | input | 14 | Current programming address |
| prot_on_i | input | 1 | Code protection active (1) |
| arr_we_o | output | 1 | Array word write enable |
| arr_addr_o | output | 14 | Array word write address |
| arr_data_o | output | 14 | Array word write data |
| busy_o | output | 1 | Row write sequence in progress |
| ers_main_o | output | 1 | Erase all of program memory |
| ers_cfg_o | output | 1 | Erase the configuration word |
| ers_uid_o | output | 1 | Erase the user-ID words |
| ers_row_o | output | 1 | Erase one program row |
| ers_row_addr_o | output | 14 | First address of the row to erase |

## Verification
A load changes its latch at the edge that accepts it. The effect shows only in the next program sequence. Word 0 of that sequence is visible in the cycle right after the accepting edge, and word k follows k cycles later. Erase strobes are due exactly one cycle after the accepting edge and last one cycle. The bench drives every request at a falling edge and samples at the following falling edges. This places each check half a cycle after the edge that makes its result due. The check is repeated on every cycle of a sequence, so a late, early or stretched result is seen.

// File: rtl/rwl_pkg.sv
// Shared defaults and types for the row write latch and erase controller.
// Assumes a word-addressed array whose top address bit selects configuration space.
package rwl_pkg;
    localparam int WORD_W_D   = 14;  // array word width
    localparam int ADDR_W_D   = 14;  // address width, top bit = configuration space
    localparam int ROW_LOG2_D = 4;   // log2 of words per row
    localparam int UID_SPAN_D = 9;   // words at the start of config space where erase hits user IDs

    // Erase strobe bundle
    typedef struct packed {
        logic main;
        logic cfg;
        logic uid;
        logic row;
    } erase_t;
endpackage

// File: rtl/rwl_latch_bank.sv
// Bank of row write latches. Loads one word per cycle by index, reads one word
// by index, and returns every latch to the erased value on a clear pulse.
// Assumes the caller never loads and clears in the same cycle.
module rwl_latch_bank #(
    parameter int WORD_W   = rwl_pkg::WORD_W_D,
    parameter int ROW_LOG2 = rwl_pkg::ROW_LOG2_D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_i,
    input  logic [ROW_LOG2-1:0] ld_idx_i,
    input  logic [WORD_W-1:0]   ld_data_i,
    input  logic                clr_i,
    input  logic [ROW_LOG2-1:0] rd_idx_i,
    output logic [WORD_W-1:0]   rd_data_o
);
    localparam int                NWORDS = 1 << ROW_LOG2;
    localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};

    logic [WORD_W-1:0] lat_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_lat
        // Hold one latch: load on index match, else erase on clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q[g] <= ERASED;
            end else if (ld_i && ld_idx_i == ROW_LOG2'(g)) begin
                lat_q[g] <= ld_data_i;
            end else if (clr_i) begin
                lat_q[g] <= ERASED;
            end
        end
    end

    // Word selected for the array write port
    always_comb begin
        rd_data_o = lat_q[rd_idx_i];
    end

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ld_i) |=> (lat_q[0] == ERASED && lat_q[NWORDS-1] == ERASED));
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && ld_idx_i == '0) |=> lat_q[0] == $past(ld_data_i));
endmodule

// File: rtl/rwl_write_seq.sv
// Row write sequencer. On start it captures the row number and steps through
// every word offset, one per cycle, raising done on the final word.
// Assumes start is only given while idle.
module rwl_write_seq #(
    parameter int ADDR_W   = rwl_pkg::ADDR_W_D,
    parameter int ROW_LOG2 = rwl_pkg::ROW_LOG2_D
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [ADDR_W-ROW_LOG2-1:0] row_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [ROW_LOG2-1:0]        idx_o,
    output logic [ADDR_W-1:0]          addr_o
);
    localparam logic [ROW_LOG2-1:0] LAST = {ROW_LOG2{1'b1}};

    logic                       busy_q;
    logic [ROW_LOG2-1:0]        idx_q;
    logic [ADDR_W-ROW_LOG2-1:0] row_q;

    // Sequence state: idle, or walking offsets of the captured row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            row_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                row_q  <= row_i;
            end
        end else if (idx_q == LAST) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Present the current word address and progress flags
    always_comb begin
        busy_o = busy_q;
        done_o = busy_q && (idx_q == LAST);
        idx_o  = idx_q;
        addr_o = {row_q, idx_q};
    end

    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && idx_q != LAST) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
    p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && idx_q != LAST) |=> $stable(row_q));
    p_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && idx_q == LAST) |=> !busy_q);
endmodule

// File: rtl/rwl_erase_dec.sv
// Erase decoder. Turns accepted bulk and row erase requests into one-cycle
// region strobes chosen by the address region and the protection bit.
// Assumes at most one of bulk_i / row_i is high in a cycle.
module rwl_erase_dec #(
    parameter int ADDR_W   = rwl_pkg::ADDR_W_D,
    parameter int ROW_LOG2 = rwl_pkg::ROW_LOG2_D,
    parameter int UID_SPAN = rwl_pkg::UID_SPAN_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bulk_i,
    input  logic              row_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              prot_i,
    output rwl_pkg::erase_t   stb_o,
    output logic [ADDR_W-1:0] row_addr_o
);
    localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] UID_LAST = CFG_BASE + ADDR_W'(UID_SPAN - 1);

    logic            in_main;
    logic            in_uid;
    rwl_pkg::erase_t nxt;
    rwl_pkg::erase_t stb_q;
    logic [ADDR_W-1:0] row_addr_q;

    // Classify the address and pick which regions this request clears
    always_comb begin
        in_main = !addr_i[ADDR_W-1];
        in_uid  = addr_i[ADDR_W-1] && (addr_i <= UID_LAST);
        nxt     = '0;
        if (bulk_i) begin
            nxt.main = in_main || in_uid;
            nxt.cfg  = in_main || in_uid;
            nxt.uid  = in_uid;
        end else if (row_i) begin
            nxt.row = in_main && !prot_i;
            nxt.uid = in_uid;
        end
    end

    // Register the strobes so each lasts exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q      <= '0;
            row_addr_q <= '0;
        end else begin
            stb_q      <= nxt;
            row_addr_q <= {addr_i[ADDR_W-1:ROW_LOG2], {ROW_LOG2{1'b0}}};
        end
    end

    assign stb_o      = stb_q;
    assign row_addr_o = row_addr_q;

    p_bulk_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q.main |-> stb_q.cfg);
    p_row_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (row_i && prot_i) |=> !stb_q.row);
    p_above_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bulk_i || row_i) && addr_i > UID_LAST) |=> (stb_q == '0));
    p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bulk_i && !row_i) |=> (stb_q == '0));
endmodule

// File: rtl/rwl_row_programmer.sv
// Row write latch and erase controller top. Arbitrates the requests, fills the
// latch bank, streams whole aligned rows to the array and issues erase strobes.
// Assumes request inputs are single-cycle pulses synchronous to clk.
module rwl_row_programmer #(
    parameter int WORD_W   = rwl_pkg::WORD_W_D,
    parameter int ADDR_W   = rwl_pkg::ADDR_W_D,
    parameter int ROW_LOG2 = rwl_pkg::ROW_LOG2_D,
    parameter int UID_SPAN = rwl_pkg::UID_SPAN_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_load_i,
    input  logic              req_prog_i,
    input  logic              req_bulk_i,
    input  logic              req_row_i,
    input  logic [WORD_W-1:0] req_data_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic              prot_on_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [WORD_W-1:0] arr_data_o,
    output logic              busy_o,
    output logic              ers_main_o,
    output logic              ers_cfg_o,
    output logic              ers_uid_o,
    output logic              ers_row_o,
    output logic [ADDR_W-1:0] ers_row_addr_o
);
    logic                go_prog, go_bulk, go_row, go_load;
    logic                busy, done;
    logic [ROW_LOG2-1:0] rd_idx;
    rwl_pkg::erase_t     stb;

    // Accept at most one request per cycle, by priority, and none while busy
    always_comb begin
        go_prog = req_prog_i && !busy;
        go_bulk = req_bulk_i && !busy && !req_prog_i;
        go_row  = req_row_i  && !busy && !req_prog_i && !req_bulk_i;
        go_load = req_load_i && !busy && !req_prog_i && !req_bulk_i && !req_row_i;
    end

    rwl_latch_bank #(.WORD_W(WORD_W), .ROW_LOG2(ROW_LOG2)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (go_load),
        .ld_idx_i  (cur_addr_i[ROW_LOG2-1:0]),
        .ld_data_i (req_data_i),
        .clr_i     (done),
        .rd_idx_i  (rd_idx),
        .rd_data_o (arr_data_o)
    );

    rwl_write_seq #(.ADDR_W(ADDR_W), .ROW_LOG2(ROW_LOG2)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go_prog),
        .row_i   (cur_addr_i[ADDR_W-1:ROW_LOG2]),
        .busy_o  (busy),
        .done_o  (done),
        .idx_o   (rd_idx),
        .addr_o  (arr_addr_o)
    );

    rwl_erase_dec #(.ADDR_W(ADDR_W), .ROW_LOG2(ROW_LOG2), .UID_SPAN(UID_SPAN)) u_ers (
        .clk        (clk),
        .rst_n      (rst_n),
        .bulk_i     (go_bulk),
        .row_i      (go_row),
        .addr_i     (cur_addr_i),
        .prot_i     (prot_on_i),
        .stb_o      (stb),
        .row_addr_o (ers_row_addr_o)
    );

    // Drive the strobe and write-enable ports
    always_comb begin
        arr_we_o   = busy;
        busy_o     = busy;
        ers_main_o = stb.main;
        ers_cfg_o  = stb.cfg;
        ers_uid_o  = stb.uid;
        ers_row_o  = stb.row;
    end

    p_no_erase_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !(ers_main_o || ers_uid_o || ers_row_o));
    p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ers_row_o, ers_uid_o && !ers_main_o, ers_main_o}));
endmodule

// File: tb/rwl_row_programmer_bench.sv
`timescale 1ns/1ps
module rwl_row_programmer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_load = 0, req_prog = 0, req_bulk = 0, req_row = 0;
    logic [13:0] req_data = '0, cur_addr = '0;
    logic        prot_on = 0;
    logic        arr_we, busy, ers_main, ers_cfg, ers_uid, ers_row;
    logic [13:0] arr_addr, arr_data, ers_row_addr;

    int errs = 0;
    int checks = 0;
    logic [13:0] exp_row [16];

    always #5 clk = ~clk;

    rwl_row_programmer u_rwl_row_programmer (
        .clk(clk), .rst_n(rst_n),
        .req_load_i(req_load), .req_prog_i(req_prog), .req_bulk_i(req_bulk),
        .req_row_i(req_row), .req_data_i(req_data), .cur_addr_i(cur_addr),
        .prot_on_i(prot_on), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
        .arr_data_o(arr_data), .busy_o(busy), .ers_main_o(ers_main),
        .ers_cfg_o(ers_cfg), .ers_uid_o(ers_uid), .ers_row_o(ers_row),
        .ers_row_addr_o(ers_row_addr)
    );

    // Vector: {is_bulk, prot, addr[13:0], exp main,cfg,uid,row}
    localparam logic [19:0] VEC [12] = '{
        {1'b1, 1'b0, 14'h0000, 4'b1100},
        {1'b1, 1'b1, 14'h1FFF, 4'b1100},
        {1'b1, 1'b1, 14'h2000, 4'b1110},
        {1'b1, 1'b0, 14'h2008, 4'b1110},
        {1'b1, 1'b0, 14'h2009, 4'b0000},
        {1'b1, 1'b1, 14'h3FFF, 4'b0000},
        {1'b0, 1'b0, 14'h0123, 4'b0001},
        {1'b0, 1'b1, 14'h0123, 4'b0000},
        {1'b0, 1'b1, 14'h2004, 4'b0010},
        {1'b0, 1'b0, 14'h2008, 4'b0010},
        {1'b0, 1'b0, 14'h2009, 4'b0000},
        {1'b0, 1'b0, 14'h1FFF, 4'b0001}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_word(input logic [13:0] a, input logic [13:0] d);
        @(negedge clk);
        cur_addr = a; req_data = d; req_load = 1;
        @(negedge clk);
        req_load = 0;
    endtask

    // Issue a program request at address a and check all 16 words against exp_row.
    // inj_bulk/inj_load: offset at which to inject that request while busy (-1 = none).
    task automatic prog_check(input logic [13:0] a, input string tag,
                              input int inj_bulk, input int inj_load);
        @(negedge clk);
        cur_addr = a; req_prog = 1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            req_prog = 0; req_bulk = 0; req_load = 0;
            chk(arr_we && busy, tag, {arr_we, busy}, 3);
            chk(arr_addr == {a[13:4], 4'(k)}, tag, arr_addr, {a[13:4], 4'(k)});
            chk(arr_data == exp_row[k], tag, arr_data, exp_row[k]);
            chk(!ers_main && !ers_cfg, "R10 no erase while busy", ers_main, 0);
            if (k == inj_bulk) begin cur_addr = 14'h0000; req_bulk = 1; end
            if (k == inj_load) begin cur_addr = 14'h0000; req_data = 14'h0001; req_load = 1; end
        end
        @(negedge clk);
        req_bulk = 0; req_load = 0;
        chk(!arr_we && !busy, {tag, " end"}, {arr_we, busy}, 0);
        chk(!ers_main, "R10 no erase after busy", ers_main, 0);
    endtask

    task automatic fill_erased;
        for (int k = 0; k < 16; k++) exp_row[k] = 14'h3FFF;
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!arr_we && !busy, "R1 write idle", {arr_we, busy}, 0);
        chk({ers_main, ers_cfg, ers_uid, ers_row} == 4'b0, "R1 strobes", {ers_main, ers_cfg, ers_uid, ers_row}, 0);

        // Erase vector table: R6 R7 R8 R9
        foreach (VEC[i]) begin
            string tg;
            logic [13:0] a;
            a = VEC[i][17:4];
            if (VEC[i][19]) tg = a[13] ? "R7" : "R6";
            else            tg = a[13] ? "R9" : "R8";
            @(negedge clk);
            cur_addr = a; prot_on = VEC[i][18];
            req_bulk = VEC[i][19]; req_row = !VEC[i][19];
            @(negedge clk);
            req_bulk = 0; req_row = 0;
            chk({ers_main, ers_cfg, ers_uid, ers_row} == VEC[i][3:0], tg,
                {ers_main, ers_cfg, ers_uid, ers_row}, VEC[i][3:0]);
            if (VEC[i][0])
                chk(ers_row_addr == {a[13:4], 4'h0}, {tg, " row addr"}, ers_row_addr, {a[13:4], 4'h0});
            @(negedge clk);
            chk({ers_main, ers_cfg, ers_uid, ers_row} == 4'b0, {tg, " one cycle"},
                {ers_main, ers_cfg, ers_uid, ers_row}, 0);
        end
        prot_on = 0;

        // R1/R5: reset latches are 3FFFh, row snapped from 0045h to 0040h (R3)
        fill_erased();
        prog_check(14'h0045, "R1 R3 R5 blank row", -1, -1);

        // R2 load by low bits, R4 overwrite, R3 snap to row of program-time address
        load_word(14'h0102, 14'h1234);
        load_word(14'h010F, 14'h0AAA);
        load_word(14'h0112, 14'h0555);
        fill_erased();
        exp_row[2] = 14'h0555; exp_row[15] = 14'h0AAA;
        prog_check(14'h0233, "R2 R4 R3 loaded row", -1, -1);

        // R4: seventeen loads wrap onto latch 0
        for (int k = 0; k < 17; k++) load_word(14'h0300 + 14'(k), 14'(k + 1));
        for (int k = 0; k < 16; k++) exp_row[k] = 14'(k + 1);
        exp_row[0] = 14'd17;
        prog_check(14'h0300, "R4 wrap", -1, -1);

        // R5: latches cleared after sequence; R10: bulk and load during busy ignored
        fill_erased();
        prog_check(14'h0010, "R5 cleared", 3, 15);
        prog_check(14'h0020, "R10 load while busy", -1, -1);

        // R10: program beats load in same cycle
        @(negedge clk);
        cur_addr = 14'h0004; req_data = 14'h0077; req_load = 1; req_prog = 1;
        @(negedge clk);
        req_load = 0; req_prog = 0;
        chk(arr_we && arr_data == 14'h3FFF, "R10 prog over load", arr_data, 14'h3FFF);
        wait (!busy);
        @(negedge clk);

        // R10: bulk beats row in same cycle
        cur_addr = 14'h0050; req_bulk = 1; req_row = 1;
        @(negedge clk);
        req_bulk = 0; req_row = 0;
        chk(ers_main && !ers_row, "R10 bulk over row", {ers_main, ers_row}, 2);

        // R1: reset mid-sequence returns to idle
        @(negedge clk);
        cur_addr = 14'h0000; req_prog = 1;
        @(negedge clk);
        req_prog = 0; rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk(!arr_we && !busy, "R1 reset mid-write", {arr_we, busy}, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule